// File: doc/BRIEF.md
# Two-Queue Conversion Status and Interrupt Controller

This block holds the status flags and drives the interrupt requests of a sequencer that runs two queues of conversions. Each queue reports two kinds of event, all as single-cycle pulses. One event says the result of the queue's final command word has been stored. The other says the queue has paused. Every event sets a sticky flag of its own, and every flag has an enable bit of its own. Each queue drives its own interrupt request line, which is the registered OR of that queue's enabled flags.

Software reads the flags through a status port and writes the enables through an enable port. It can run polled, with all enables off, or interrupt-driven. To clear a flag, software must first read the status, then write a zero to that bit. Each bit remembers whether it was seen set by the most recent read. An event that arrives between the read and the write erases that memory, so the event is never lost.

Status and enable vectors share one layout for queue q (q counting from 0). Bit 2q is the completion flag and bit 2q+1 is the pause flag. `irq[q]` serves queue q.

Top module: `qfic_top`

## Requirements
- R1: A pulse on `done_evt[q]` or `pause_evt[q]` sets status bit 2q or 2q+1 respectively, visible on `stat_rdata` one clock later. A flag never sets without its event.
- R2: Flags set whatever the enable bits hold, so with all enables zero the flags can be polled.
- R3: `irq[q]` equals, one clock later, the OR over bits 2q and 2q+1 of (flag AND enable).
- R4: Once raised, `irq[q]` stays high until the flag that caused it is cleared or disabled.
- R5: A status read (`stat_rd`) marks each bit that is set at that moment. A later write (`stat_wr`) with a zero in a marked bit clears that flag on the next clock.
- R6: Writing a one to a status bit leaves that flag unchanged.
- R7: Writing a zero to a bit that was not seen set by the last read leaves that flag unchanged.
- R8: An event on a bit after the read and before the write erases that bit's mark, so the write does not clear it.
- R9: When an event and a valid clear hit the same bit in the same cycle, the flag stays set.
- R10: Any status write consumes all marks; a second zero-write with no read in between clears nothing.
- R11: After reset, all flags, marks, enables and both interrupt lines are zero.
- R12: `en_wr` loads `en_wdata` into the enable register, and `en_rdata` shows it from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_evt | input | NQ | Completion pulse per queue |
| pause_evt | input | NQ | Pause pulse per queue |
| stat_rd | input | 1 | Status read strobe; marks the set bits |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 2*NQ | Status write data; zero clears a marked bit |
| stat_rdata | output | 2*NQ | Current flags |
| en_wr | input | 1 | Enable write strobe |
| en_wdata | input | 2*NQ | Enable write data |
| en_rdata | output | 2*NQ | Current enables |
| irq | output | NQ | Interrupt request per queue |

## Verification
The hardest situation to reach is a flag that is marked by a read, receives a fresh event, and is then hit by a zero-write. Within that, the event may arrive a cycle before the write or in the same cycle. The stimulus first sets the pause flag of the second queue and reads it. It then drives a second pause pulse either in the cycle between read and write or together with the write strobe. A behavioural model in the bench follows the mark of every bit and checks that the flag survives both times. A plain read-and-write afterwards must then clear it.

// File: rtl/qfic_pkg.sv
package qfic_pkg;
   localparam int SRC_PER_Q = 2;
   typedef enum logic [0:0] { SRC_DONE = 1'b0, SRC_PAUSE = 1'b1 } qfic_src_e;

   function automatic int flag_idx(input int q, input qfic_src_e s);
      return q * SRC_PER_Q + int'(s);
   endfunction
endpackage

// File: rtl/qfic_flag_cell.sv
module qfic_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic rd,
   input  logic wr,
   input  logic wbit,
   output logic flag,
   output logic armed
);
   logic clr_ok;

   // a zero written to a bit that the last read saw set
   assign clr_ok = wr & armed & ~wbit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         armed <= 1'b0;
      end else begin
         // event beats clear
         flag <= evt | (flag & ~clr_ok);
         if (evt || wr)
            armed <= 1'b0;
         else if (rd)
            armed <= flag;
      end
   end
endmodule

// File: rtl/qfic_irq_merge.sv
module qfic_irq_merge #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] flags,
   input  logic [W-1:0] enables,
   output logic         req
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         req <= 1'b0;
      else
         req <= |(flags & enables);
   end
endmodule

// File: rtl/qfic_top.sv
module qfic_top #(
   parameter int NQ = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NQ-1:0]   done_evt,
   input  logic [NQ-1:0]   pause_evt,
   input  logic            stat_rd,
   input  logic            stat_wr,
   input  logic [2*NQ-1:0] stat_wdata,
   output logic [2*NQ-1:0] stat_rdata,
   input  logic            en_wr,
   input  logic [2*NQ-1:0] en_wdata,
   output logic [2*NQ-1:0] en_rdata,
   output logic [NQ-1:0]   irq
);
   import qfic_pkg::*;
   localparam int NF = NQ * SRC_PER_Q;

   if (NQ < 1 || NQ > 16) begin : g_bad_nq
      $error("qfic_top: NQ must be in 1..16");
   end
   if (NF != 2 * NQ) begin : g_bad_src
      $error("qfic_top: port layout assumes two sources per queue");
   end

   logic [NF-1:0] evt_vec;
   logic [NF-1:0] flags;
   logic [NF-1:0] armed;
   logic [NF-1:0] en_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= '0;
      else if (en_wr)
         en_q <= en_wdata;
   end

   for (genvar q = 0; q < NQ; q++) begin : g_queue
      assign evt_vec[flag_idx(q, SRC_DONE)]  = done_evt[q];
      assign evt_vec[flag_idx(q, SRC_PAUSE)] = pause_evt[q];

      qfic_irq_merge #(.W(SRC_PER_Q)) u_merge (
         .clk     (clk),
         .rst_n   (rst_n),
         .flags   (flags[q*SRC_PER_Q +: SRC_PER_Q]),
         .enables (en_q[q*SRC_PER_Q +: SRC_PER_Q]),
         .req     (irq[q])
      );
   end

   for (genvar i = 0; i < NF; i++) begin : g_flag
      qfic_flag_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .evt   (evt_vec[i]),
         .rd    (stat_rd),
         .wr    (stat_wr),
         .wbit  (stat_wdata[i]),
         .flag  (flags[i]),
         .armed (armed[i])
      );
   end

   assign stat_rdata = flags;
   assign en_rdata   = en_q;
endmodule

// File: rtl/qfic_top_chk.sv
module qfic_top_chk #(
   parameter int NQ = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NQ-1:0]   done_evt,
   input logic [NQ-1:0]   pause_evt,
   input logic            stat_wr,
   input logic [2*NQ-1:0] stat_wdata,
   input logic [2*NQ-1:0] stat_rdata,
   input logic [2*NQ-1:0] en_rdata,
   input logic [2*NQ-1:0] armed,
   input logic [NQ-1:0]   irq
);
   logic [2*NQ-1:0] ev;
   for (genvar q = 0; q < NQ; q++) begin : g_ev
      assign ev[2*q]   = done_evt[q];
      assign ev[2*q+1] = pause_evt[q];

      p_irq_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> irq[q] == $past(|(stat_rdata[2*q +: 2] & en_rdata[2*q +: 2])));
   end

   for (genvar i = 0; i < 2*NQ; i++) begin : g_bit
      p_evt_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
         ev[i] |=> stat_rdata[i]);
      p_no_self_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (!stat_rdata[i] && !ev[i]) |=> !stat_rdata[i]);
      p_marked_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (armed[i] && stat_wr && !stat_wdata[i] && !ev[i]) |=> !stat_rdata[i]);
      p_one_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_rdata[i] && stat_wr && stat_wdata[i]) |=> stat_rdata[i]);
      p_unmarked_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_rdata[i] && stat_wr && !armed[i]) |=> stat_rdata[i]);
      p_write_consumes_r10: assert property (@(posedge clk) disable iff (!rst_n)
         stat_wr |=> !armed[i]);
   end
endmodule

bind qfic_top qfic_top_chk #(.NQ(NQ)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .done_evt   (done_evt),
   .pause_evt  (pause_evt),
   .stat_wr    (stat_wr),
   .stat_wdata (stat_wdata),
   .stat_rdata (stat_rdata),
   .en_rdata   (en_rdata),
   .armed      (armed),
   .irq        (irq)
);

// File: tb/qfic_top_test.sv
module qfic_top_test;
   localparam int NQ = 2;
   localparam int NF = 2 * NQ;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NQ-1:0] done_evt = '0, pause_evt = '0;
   logic stat_rd = 1'b0, stat_wr = 1'b0, en_wr = 1'b0;
   logic [NF-1:0] stat_wdata = '0, en_wdata = '0;
   logic [NF-1:0] stat_rdata, en_rdata;
   logic [NQ-1:0] irq;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   qfic_top #(.NQ(NQ)) uut (
      .clk, .rst_n, .done_evt, .pause_evt, .stat_rd, .stat_wr, .stat_wdata,
      .stat_rdata, .en_wr, .en_wdata, .en_rdata, .irq
   );

   // behavioural reference: per-bit flag, per-bit "seen set" mark
   bit m_flag [NF];
   bit m_seen [NF];
   bit m_en   [NF];
   bit m_irq  [NQ];

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_flag[i]) begin m_flag[i] = 0; m_seen[i] = 0; m_en[i] = 0; end
         foreach (m_irq[q]) m_irq[q] = 0;
      end else begin
         foreach (m_irq[q])
            m_irq[q] = (m_flag[2*q] && m_en[2*q]) || (m_flag[2*q+1] && m_en[2*q+1]);
         foreach (m_flag[i]) begin
            bit e;
            e = (i % 2 == 0) ? done_evt[i/2] : pause_evt[i/2];
            if (e) begin
               m_flag[i] = 1; m_seen[i] = 0;
            end else if (stat_wr) begin
               if (m_seen[i] && !stat_wdata[i]) m_flag[i] = 0;
               m_seen[i] = 0;
            end else if (stat_rd) begin
               m_seen[i] = m_flag[i];
            end
         end
         if (en_wr) foreach (m_en[i]) m_en[i] = en_wdata[i];
      end
   end

   function automatic logic [NF-1:0] mflags();
      logic [NF-1:0] v;
      foreach (m_flag[i]) v[i] = m_flag[i];
      return v;
   endfunction
   function automatic logic [NF-1:0] mens();
      logic [NF-1:0] v;
      foreach (m_en[i]) v[i] = m_en[i];
      return v;
   endfunction
   function automatic logic [NQ-1:0] mirqs();
      logic [NQ-1:0] v;
      foreach (m_irq[q]) v[q] = m_irq[q];
      return v;
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // continuous comparison with the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R1 R5 flags vs model", 8'(stat_rdata), 8'(mflags()));
         chk("R3 R4 irq vs model", 8'(irq), 8'(mirqs()));
         chk("R12 enables vs model", 8'(en_rdata), 8'(mens()));
      end
   end

   task automatic drive(input bit rd, input bit wr, input logic [NF-1:0] wd,
                        input bit ew, input logic [NF-1:0] ewd,
                        input logic [NQ-1:0] dn, input logic [NQ-1:0] ps);
      stat_rd = rd; stat_wr = wr; stat_wdata = wd;
      en_wr = ew; en_wdata = ewd; done_evt = dn; pause_evt = ps;
      @(negedge clk); #1;
      stat_rd = 0; stat_wr = 0; stat_wdata = '0;
      en_wr = 0; en_wdata = '0; done_evt = '0; pause_evt = '0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin @(negedge clk); #1; end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      idle(1);
      chk("R11 flags after reset", 8'(stat_rdata), 8'h0);
      chk("R11 irq after reset", 8'(irq), 8'h0);
      chk("R11 enables after reset", 8'(en_rdata), 8'h0);

      // queue 0 completion and queue 1 pause with enables off
      drive(0, 0, '0, 0, '0, 2'b01, 2'b10);
      idle(2);
      chk("R1 R2 polled flags", 8'(stat_rdata), 8'h9);
      chk("R2 no irq when disabled", 8'(irq), 8'h0);

      drive(0, 0, '0, 1, 4'b0001, '0, '0);
      chk("R12 enable readback", 8'(en_rdata), 8'h1);
      idle(1);
      chk("R3 irq0 raised", 8'(irq), 8'h1);

      drive(0, 1, 4'b0000, 0, '0, '0, '0);
      idle(2);
      chk("R7 unread zero-write keeps", 8'(stat_rdata), 8'h9);
      chk("R4 irq held", 8'(irq), 8'h1);

      drive(1, 0, '0, 0, '0, '0, '0);
      drive(0, 1, 4'b1110, 0, '0, '0, '0);
      chk("R5 R6 clear bit0 keep bit3", 8'(stat_rdata), 8'h8);
      idle(1);
      chk("R4 irq drops after clear", 8'(irq), 8'h0);

      drive(0, 1, 4'b0000, 0, '0, '0, '0);
      chk("R10 mark consumed", 8'(stat_rdata), 8'h8);

      // event between read and write
      drive(1, 0, '0, 0, '0, '0, '0);
      drive(0, 0, '0, 0, '0, '0, 2'b10);
      drive(0, 1, 4'b0000, 0, '0, '0, '0);
      chk("R8 event after read survives", 8'(stat_rdata), 8'h8);

      // event together with a valid clear
      drive(1, 0, '0, 0, '0, '0, '0);
      drive(0, 1, 4'b0000, 0, '0, '0, 2'b10);
      chk("R9 event beats clear", 8'(stat_rdata), 8'h8);

      drive(1, 0, '0, 0, '0, '0, '0);
      drive(0, 1, 4'b0000, 0, '0, '0, '0);
      chk("R5 plain clear", 8'(stat_rdata), 8'h0);

      // queue 1 interrupt path via pause and completion
      drive(0, 0, '0, 1, 4'b1100, 2'b10, '0);
      idle(2);
      chk("R3 irq1 raised", 8'(irq), 8'h2);
      drive(0, 0, '0, 1, 4'b0000, '0, '0);
      idle(1);
      chk("R3 irq1 off when disabled", 8'(irq), 8'h0);

      // mixed traffic, model compared each clock
      for (int k = 0; k < 200; k++) begin
         logic [NF-1:0] r;
         r = NF'($urandom);
         drive(k % 3 == 0, k % 5 == 1, NF'($urandom), k % 7 == 2, r,
               NQ'($urandom) & NQ'($urandom), NQ'($urandom) & NQ'($urandom));
      end
      idle(3);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         mismatched++;
         compared++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule